// File: doc/BRIEF.md
# Bus-0 Configuration Function Router

This block sits behind the configuration-cycle path of a chip's root bus. Each request names a device number, a function number and a dword register offset, and carries a read/write flag, write data and byte enables. The block matches the device/function pair against a fixed table of functions, each of which has a small type-0 header. It then decides, from strap inputs, whether the cycle is serviced, hidden or left unanswered. A serviced cycle reaches that function's header registers. A hidden cycle behaves like a master abort: reads return all ones and writes are dropped. An unanswered cycle produces no completion at all, so software sees no function at that address.

There are two groups of functions. In the memory-controller group, slots 0 to 5, a function that is disabled or missing is hidden. In the I/O-controller group, slots 6 to 10, a disabled function gives no response. Each of the two link ports is hidden when its link has not trained. The second port is also hidden whenever the first port is strapped for the wide (x8) link. The vendor ID, the base device ID and the revision ID are parameters.

Top module: `cfg_func_router`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `rsp_valid` and `rsp_silent` are 0 and `rsp_rdata` is 0.
- R2: The slot table maps device/function pairs as follows: slot 0 = 0/0, slot 1 = 0/1, slot 2 = 1/0, slot 3 = 2/0 (first link port), slot 4 = 8/0, slot 5 = 3/0 (second link port), slot 6 = 31/0, slot 7 = 31/2, slot 8 = 31/3, slot 9 = 29/0, slot 10 = 29/7. Bit n of `fn_en` enables slot n.
- R3: Dword 0 of a serviced function reads as {device ID, vendor ID}, with the device ID in bits 31:16. The device ID equals DEV_ID_BASE plus the slot number.
- R4: Dword 2 reads as {class code, revision ID}, with the revision in bits 7:0. The class code of each slot, from slot 0 to slot 10, is 060000h, 088000h, 088000h, 060400h, 088000h, 060400h, 060100h, 010601h, 0C0500h, 0C0300h and 0C0320h. Slot 0 is therefore base class 06h (bridge), sub-class 00h (host bridge).
- R5: Bits 23:16 of dword 3 hold the header type. It is 80h (bit 7 is the multi-function flag) for the functions of devices 0, 29 and 31, and 00h for all other functions.
- R6: Two fields of a serviced function are writable, and each resets to 0: bits 15:0 of dword 1 and bits 15:0 of dword 3. Byte enable bit b gates byte b of a write. Writes to any other bits are ignored. Any other dword offset reads as 0.
- R7: A request that is serviced or hidden raises `rsp_valid` for exactly one cycle, in the cycle after the request. A request that gets no response raises `rsp_silent` in that cycle instead, never together with `rsp_valid`. Write completions return `rsp_rdata` = 0.
- R8: A memory-controller-group slot with its `fn_en` bit low, and any device/function pair missing from the table, is hidden: reads return FFFFFFFFh and writes change no register.
- R9: An I/O-group slot with its `fn_en` bit low gets no response and ignores writes. Device 31 functions 5 and 6 are reserved and never respond.
- R10: The first link port (slot 3) is hidden when `link_up[0]` is 0. The second link port (slot 5) is hidden when `link_up[1]` is 0.
- R11: When `port_a_wide` is 1, the second link port (slot 5) is hidden whatever its link state.
- R12: A cycle with no request is followed by a cycle with neither `rsp_valid` nor `rsp_silent`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Configuration request present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_reg | input | 6 | Dword register offset |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for a write |
| fn_en | input | 11 | Per-slot enable straps |
| link_up | input | 2 | Link-trained flags of the two link ports |
| port_a_wide | input | 1 | First link port strapped for the wide link |
| rsp_valid | output | 1 | Completion strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data of the completion |
| rsp_silent | output | 1 | The request got no response |

## Verification
If the decode or the strap gating holds a wrong value, the completion that follows the request in the next cycle takes the wrong kind. A serviced read returns all ones, a hidden read returns header data, or `rsp_silent` appears where `rsp_valid` should. A corrupted writable field does not show up at once. It shows on the next read of that dword, and a write that should have been dropped shows when the function is re-enabled and read back. Because of this, the stimulus interleaves writes with read-backs while the straps keep changing.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
  localparam int DEV_W   = 5;
  localparam int FN_W    = 3;
  localparam int REG_W   = 6;
  localparam int DATA_W  = 32;
  localparam int BE_W    = DATA_W / 8;
  localparam int NSLOT   = 11;
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int PORT_A  = 3;
  localparam int PORT_B  = 5;
  localparam int FIRST_IO = 6;
  localparam int WR_BYTES = 2;

  typedef enum logic [1:0] {OUT_NORMAL, OUT_HIDDEN, OUT_SILENT} outcome_t;

  function automatic logic [23:0] slot_class(input logic [SLOT_W-1:0] s);
    case (s)
      4'd0:          return 24'h060000;
      4'd3, 4'd5:    return 24'h060400;
      4'd6:          return 24'h060100;
      4'd7:          return 24'h010601;
      4'd8:          return 24'h0C0500;
      4'd9:          return 24'h0C0300;
      4'd10:         return 24'h0C0320;
      default:       return 24'h088000;
    endcase
  endfunction

  function automatic logic slot_multi(input logic [SLOT_W-1:0] s);
    return (s <= 4'd1) || (s >= 4'd6);
  endfunction
endpackage

// File: rtl/cfgr_decode.sv
module cfgr_decode
  import cfgr_pkg::*;
(
  input  logic [DEV_W-1:0]  dev,
  input  logic [FN_W-1:0]   fn,
  output logic              hit,
  output logic              rsvd,
  output logic [SLOT_W-1:0] slot
);
  always_comb begin
    hit  = 1'b1;
    rsvd = 1'b0;
    slot = '0;
    case ({dev, fn})
      {5'd0,  3'd0}: slot = 4'd0;
      {5'd0,  3'd1}: slot = 4'd1;
      {5'd1,  3'd0}: slot = 4'd2;
      {5'd2,  3'd0}: slot = 4'd3;
      {5'd8,  3'd0}: slot = 4'd4;
      {5'd3,  3'd0}: slot = 4'd5;
      {5'd31, 3'd0}: slot = 4'd6;
      {5'd31, 3'd2}: slot = 4'd7;
      {5'd31, 3'd3}: slot = 4'd8;
      {5'd29, 3'd0}: slot = 4'd9;
      {5'd29, 3'd7}: slot = 4'd10;
      {5'd31, 3'd5},
      {5'd31, 3'd6}: begin hit = 1'b0; rsvd = 1'b1; end
      default:       hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfgr_gate.sv
module cfgr_gate
  import cfgr_pkg::*;
(
  input  logic              hit,
  input  logic              rsvd,
  input  logic [SLOT_W-1:0] slot,
  input  logic [NSLOT-1:0]  fn_en,
  input  logic [1:0]        link_up,
  input  logic              port_a_wide,
  output outcome_t          outcome
);
  logic slot_on;
  assign slot_on = fn_en[slot];

  always_comb begin
    if (rsvd)                          outcome = OUT_SILENT;
    else if (!hit)                     outcome = OUT_HIDDEN;
    else if (slot >= SLOT_W'(FIRST_IO)) outcome = slot_on ? OUT_NORMAL : OUT_SILENT;
    else if (!slot_on)                 outcome = OUT_HIDDEN;
    else if (slot == SLOT_W'(PORT_A) && !link_up[0]) outcome = OUT_HIDDEN;
    else if (slot == SLOT_W'(PORT_B) && (!link_up[1] || port_a_wide)) outcome = OUT_HIDDEN;
    else                               outcome = OUT_NORMAL;
  end
endmodule

// File: rtl/cfgr_hdr.sv
module cfgr_hdr
  import cfgr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1D0F,
  parameter logic [15:0] DEV_ID_BASE = 16'h5A00,
  parameter logic [7:0]  REVISION    = 8'h01
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic [REG_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  output logic [DATA_W-1:0] rdata
);
  localparam int FW = 8 * WR_BYTES;

  logic [FW-1:0] cmd_q  [NSLOT];
  logic [FW-1:0] misc_q [NSLOT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) begin
        cmd_q[i]  <= '0;
        misc_q[i] <= '0;
      end
    end else if (wr_en) begin
      for (int b = 0; b < WR_BYTES; b++) begin
        if (be[b] && reg_idx == REG_W'(1)) cmd_q[slot][8*b +: 8]  <= wdata[8*b +: 8];
        if (be[b] && reg_idx == REG_W'(3)) misc_q[slot][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  logic [15:0] dev_id;
  logic [7:0]  hdr_type;
  assign dev_id   = DEV_ID_BASE + 16'(slot);
  assign hdr_type = slot_multi(slot) ? 8'h80 : 8'h00;

  always_comb begin
    case (reg_idx)
      REG_W'(0): rdata = {dev_id, VENDOR_ID};
      REG_W'(1): rdata = {{(DATA_W-FW){1'b0}}, cmd_q[slot]};
      REG_W'(2): rdata = {slot_class(slot), REVISION};
      REG_W'(3): rdata = {8'h00, hdr_type, misc_q[slot]};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_func_router.sv
module cfg_func_router
  import cfgr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1D0F,
  parameter logic [15:0] DEV_ID_BASE = 16'h5A00,
  parameter logic [7:0]  REVISION    = 8'h01
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_wr,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic [NSLOT-1:0]  fn_en,
  input  logic [1:0]        link_up,
  input  logic              port_a_wide,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_silent
);
  logic              hit, rsvd;
  logic [SLOT_W-1:0] slot;
  outcome_t          outcome;
  logic [DATA_W-1:0] hdr_rd;
  logic              wr_en;

  cfgr_decode u_dec (
    .dev(req_dev), .fn(req_fn), .hit(hit), .rsvd(rsvd), .slot(slot)
  );

  cfgr_gate u_gate (
    .hit(hit), .rsvd(rsvd), .slot(slot), .fn_en(fn_en),
    .link_up(link_up), .port_a_wide(port_a_wide), .outcome(outcome)
  );

  assign wr_en = req_valid && req_wr && outcome == OUT_NORMAL;

  cfgr_hdr #(.VENDOR_ID(VENDOR_ID), .DEV_ID_BASE(DEV_ID_BASE), .REVISION(REVISION)) u_hdr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .slot(slot), .reg_idx(req_reg),
    .wdata(req_wdata), .be(req_be), .rdata(hdr_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_silent <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid  <= req_valid && outcome != OUT_SILENT;
      rsp_silent <= req_valid && outcome == OUT_SILENT;
      if (!req_valid || req_wr)       rsp_rdata <= '0;
      else if (outcome == OUT_HIDDEN) rsp_rdata <= '1;
      else if (outcome == OUT_NORMAL) rsp_rdata <= hdr_rd;
      else                            rsp_rdata <= '0;
    end
  end
endmodule

// File: rtl/cfgr_chk.sv
module cfgr_chk
  import cfgr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_wr,
  input logic [DEV_W-1:0]  req_dev,
  input logic [FN_W-1:0]   req_fn,
  input logic              port_a_wide,
  input logic              rsp_valid,
  input logic              rsp_silent,
  input logic [DATA_W-1:0] rsp_rdata
);
  // R7
  rsp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_silent));
  // R7
  one_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_valid || rsp_silent));
  // R7
  wr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_wr) |=> rsp_rdata == '0);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_silent));
  // R11
  wide_hide_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_wr && req_dev == 5'd3 && req_fn == 3'd0 && port_a_wide)
      |=> (rsp_valid && rsp_rdata == '1));
  // R9
  rsvd_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dev == 5'd31 && (req_fn == 3'd5 || req_fn == 3'd6)) |=> rsp_silent);
endmodule

bind cfg_func_router cfgr_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr),
  .req_dev(req_dev), .req_fn(req_fn), .port_a_wide(port_a_wide),
  .rsp_valid(rsp_valid), .rsp_silent(rsp_silent), .rsp_rdata(rsp_rdata)
);

// File: tb/test_cfg_func_router.sv
`timescale 1ns/1ps
module test_cfg_func_router;
  localparam logic [15:0] VEN  = 16'h1D0F;
  localparam logic [15:0] BASE = 16'h5A00;
  localparam logic [7:0]  REV  = 8'h01;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_wr = 1'b0;
  logic [4:0] req_dev = '0;
  logic [2:0] req_fn = '0;
  logic [5:0] req_reg = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_be = '0;
  logic [10:0] fn_en = '1;
  logic [1:0] link_up = 2'b11;
  logic port_a_wide = 1'b0;
  logic rsp_valid, rsp_silent;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m_cmd [11];
  logic [15:0] m_misc[11];

  always #4 clk = ~clk;

  cfg_func_router i_cfg_func_router (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr),
    .req_dev(req_dev), .req_fn(req_fn), .req_reg(req_reg), .req_wdata(req_wdata),
    .req_be(req_be), .fn_en(fn_en), .link_up(link_up), .port_a_wide(port_a_wide),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_silent(rsp_silent)
  );

  function automatic int b_slot(input logic [4:0] d, input logic [2:0] f);
    if (d == 0 && f == 0) return 0;
    if (d == 0 && f == 1) return 1;
    if (d == 1 && f == 0) return 2;
    if (d == 2 && f == 0) return 3;
    if (d == 8 && f == 0) return 4;
    if (d == 3 && f == 0) return 5;
    if (d == 31 && f == 0) return 6;
    if (d == 31 && f == 2) return 7;
    if (d == 31 && f == 3) return 8;
    if (d == 29 && f == 0) return 9;
    if (d == 29 && f == 7) return 10;
    if (d == 31 && (f == 5 || f == 6)) return 11;
    return -1;
  endfunction

  // 0 normal, 1 hidden, 2 silent
  function automatic int b_out(input int s);
    if (s == 11) return 2;
    if (s < 0) return 1;
    if (s >= 6) return fn_en[s] ? 0 : 2;
    if (!fn_en[s]) return 1;
    if (s == 3 && !link_up[0]) return 1;
    if (s == 5 && (!link_up[1] || port_a_wide)) return 1;
    return 0;
  endfunction

  function automatic logic [23:0] b_class(input int s);
    logic [23:0] t [11] = '{24'h060000, 24'h088000, 24'h088000, 24'h060400, 24'h088000,
                            24'h060400, 24'h060100, 24'h010601, 24'h0C0500, 24'h0C0300, 24'h0C0320};
    return t[s];
  endfunction

  function automatic logic [31:0] b_read(input int s, input logic [5:0] r);
    logic [7:0] ht;
    ht = (s <= 1 || s >= 6) ? 8'h80 : 8'h00;
    case (r)
      6'd0: return {BASE + 16'(s), VEN};
      6'd1: return {16'h0, m_cmd[s]};
      6'd2: return {b_class(s), REV};
      6'd3: return {8'h0, ht, m_misc[s]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic op(input logic [4:0] d, input logic [2:0] f, input logic [5:0] r,
                    input bit wr, input logic [31:0] wd, input logic [3:0] be, input string forced_tag);
    int s, o;
    logic [31:0] er;
    string tag;
    s = b_slot(d, f);
    o = b_out(s);
    if (wr || o != 0) er = (o == 1 && !wr) ? 32'hFFFF_FFFF : 32'h0;
    else er = b_read(s, r);
    if (forced_tag != "") tag = forced_tag;
    else if (s == 5 && port_a_wide && fn_en[5]) tag = "R11";
    else if ((s == 3 || s == 5) && o == 1 && fn_en[s]) tag = "R10";
    else if (o == 1) tag = "R8";
    else if (o == 2) tag = "R9";
    else if (wr) tag = "R7";
    else if (r == 0) tag = "R3";
    else if (r == 2) tag = "R4";
    else if (r == 3) tag = "R5";
    else tag = "R6";
    @(negedge clk);
    req_valid = 1; req_wr = wr; req_dev = d; req_fn = f; req_reg = r; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid == (o != 2), {tag, " valid"}, {31'h0, rsp_valid}, {31'h0, o != 2});
    check(rsp_silent == (o == 2), {tag, " silent"}, {31'h0, rsp_silent}, {31'h0, o == 2});
    check(rsp_rdata == er, {tag, " data"}, rsp_rdata, er);
    if (wr && o == 0) begin
      for (int b = 0; b < 2; b++) begin
        if (be[b] && r == 1) m_cmd[s][8*b +: 8] = wd[8*b +: 8];
        if (be[b] && r == 3) m_misc[s][8*b +: 8] = wd[8*b +: 8];
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] dl [13] = '{5'd0, 5'd0, 5'd1, 5'd2, 5'd8, 5'd3, 5'd31, 5'd31, 5'd31, 5'd29, 5'd29, 5'd31, 5'd31};
    logic [2:0] fl [13] = '{3'd0, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd2, 3'd3, 3'd0, 3'd7, 3'd5, 3'd6};
    void'($urandom(32'd1234));
    for (int i = 0; i < 11; i++) begin m_cmd[i] = '0; m_misc[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state during and just after reset
    check(!rsp_valid && !rsp_silent && rsp_rdata == 0, "R1 in reset", rsp_rdata, 32'h0);
    rst = 0;
    @(negedge clk);
    check(!rsp_valid && !rsp_silent && rsp_rdata == 0, "R1 after reset", rsp_rdata, 32'h0);
    // R12: idle cycles give no response
    repeat (2) @(negedge clk);
    check(!rsp_valid && !rsp_silent, "R12 idle", {30'h0, rsp_valid, rsp_silent}, 32'h0);
    // R2: every table entry answers with its own device ID
    for (int k = 0; k < 11; k++) op(dl[k], fl[k], 6'd0, 0, 0, 0, "R2");
    // R4: host bridge class
    op(5'd0, 3'd0, 6'd2, 0, 0, 0, "R4");
    // R6: byte-enabled write and read-only dwords
    op(5'd2, 3'd0, 6'd1, 1, 32'hDEAD_BEEF, 4'b1111, "R6");
    op(5'd2, 3'd0, 6'd1, 0, 0, 0, "R6");
    op(5'd2, 3'd0, 6'd3, 1, 32'h1234_5678, 4'b0010, "R6");
    op(5'd2, 3'd0, 6'd3, 0, 0, 0, "R6");
    op(5'd2, 3'd0, 6'd0, 1, 32'h0, 4'b1111, "R6");
    op(5'd2, 3'd0, 6'd0, 0, 0, 0, "R6");
    // R11: wide strap hides the second port and drops its writes
    port_a_wide = 1;
    op(5'd3, 3'd0, 6'd0, 0, 0, 0, "R11");
    op(5'd3, 3'd0, 6'd1, 1, 32'h0000_A5A5, 4'b0011, "R11");
    port_a_wide = 0;
    op(5'd3, 3'd0, 6'd1, 0, 0, 0, "R11");
    // R10: untrained link hides the first port
    link_up = 2'b10;
    op(5'd2, 3'd0, 6'd0, 0, 0, 0, "R10");
    link_up = 2'b11;
    // R9: disabled I/O function is silent and keeps its state
    fn_en[7] = 0;
    op(5'd31, 3'd2, 6'd1, 1, 32'h0000_7777, 4'b0011, "R9");
    fn_en[7] = 1;
    op(5'd31, 3'd2, 6'd1, 0, 0, 0, "R9");
    op(5'd31, 3'd5, 6'd0, 0, 0, 0, "R9");
    // R8: disabled controller function and missing address are hidden
    fn_en[1] = 0;
    op(5'd0, 3'd1, 6'd3, 1, 32'h0000_4444, 4'b0011, "R8");
    fn_en[1] = 1;
    op(5'd0, 3'd1, 6'd3, 0, 0, 0, "R8");
    op(5'd5, 3'd4, 6'd0, 0, 0, 0, "R8");
    // random mix of straps and requests
    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [4:0] d;
      logic [2:0] f;
      logic [5:0] r;
      if (n % 40 == 0) begin
        fn_en = 11'($urandom) | 11'($urandom);
        link_up = 2'($urandom);
        port_a_wide = 1'($urandom);
      end
      k = int'($urandom % 16);
      if (k < 13) begin d = dl[k]; f = fl[k]; end
      else begin d = 5'($urandom); f = 3'($urandom); end
      r = ($urandom % 8 == 0) ? 6'($urandom) : 6'($urandom % 5);
      op(d, f, r, 1'($urandom), $urandom, 4'($urandom), "");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule